// File: doc/BRIEF.md
# Global-shutter frame and row readout sequencer

This block paces the readout of a global-shutter pixel array that runs in slave mode. An external exposure signal starts each frame. After a rising edge on that signal, the sequencer runs a frame overhead interval. It then reads the array row by row. Each row opens with a row overhead interval and then streams a window of 32-pixel kernels. A kernel index, a row index and a data-valid strobe steer the downstream column multiplexer and serialiser.

All overhead intervals are counted in sensor clocks, and one sensor clock is four master clocks. The register values that set the timing are held in shadow copies. These copies load only while the active-low sequencer reset is asserted, so a readout always runs on one consistent set of values. The window start is given as a start code. Each code step moves the first kernel by two kernels (64 columns). The window always runs up to the last kernel of the row.

Top module: `readout_seq`

## Requirements
- R1: While rst_ni is low, fot_o, rot_o and valid_o are low and row_o and kernel_o are zero.
- R2: A rising edge on exposure_i, seen while the sequencer is idle and the sequencer reset is released, drives fot_o high in the next cycle. fot_o then stays high for exactly (4*F+2)*4 master clocks, where F is the 8-bit frame overhead value.
- R3: Each row begins with rot_o high for exactly (R+2)*4 master clocks, where R is the 5-bit row overhead value.
- R4: After rst_ni, with the sequencer reset never asserted, the shadow values are R=7 (36 clocks), F=40 (648 clocks) and start code 0.
- R5: Start code c selects kernel 2*c as the first kernel of each row. Codes above (NUM_KERNELS-1)/2 act as that largest code. Every row ends at kernel NUM_KERNELS-1.
- R6: valid_o is high only while kernels stream. Each kernel lasts 4 master clocks, and kernel_o rises by one from each kernel to the next.
- R7: A frame holds NUM_ROWS rows, numbered 0 upward on row_o. The frame overhead, each row overhead and each kernel run follow one another with no idle cycle between them.
- R8: While seq_rst_ni is low, from the next cycle on, fot_o, rot_o and valid_o are low, and the configuration inputs load into the shadows. While seq_rst_ni is high, changes on the configuration inputs have no effect, and no readout starts without a new exposure edge.
- R9: Exposure edges seen during a frame are latched as one request. The next frame overhead then starts in the cycle after the last kernel of the frame. A level held high, or an edge seen while seq_rst_ni is low, starts nothing.
- R10: At most one of fot_o, rot_o and valid_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seq_rst_ni | input | 1 | Synchronous active-low sequencer reset; shadows load while low |
| exposure_i | input | 1 | Exposure start; rising edge requests a frame |
| rot_cfg_i | input | 5 | Row overhead value R |
| fot_cfg_i | input | 8 | Frame overhead value F |
| start_cfg_i | input | 5 | Window start code |
| rot_o | output | 1 | Row overhead strobe |
| fot_o | output | 1 | Frame overhead strobe |
| row_o | output | clog2(NUM_ROWS) | Current row index |
| kernel_o | output | clog2(NUM_KERNELS) | Current kernel index |
| valid_o | output | 1 | High while a kernel is streamed |

## Verification
The length checks compare each strobe's run against the live shadow-derived length. They assume the configuration inputs do not move the shadows mid-frame, which holds because the shadows load only while the sequencer reset is asserted. A run cut short by that reset is excluded through the sequencer-reset term. The stimulus changes configuration inputs only inside a sequencer-reset window, except in the test that deliberately changes them during a frame. The exposure input is driven as a plain level held for at least one cycle. Every frame is allowed to drain to idle before the next configuration is loaded.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FOT  = 2'd1,
    ST_ROT  = 2'd2,
    ST_READ = 2'd3
  } seq_state_e;
endpackage

// File: rtl/readout_seq_shadow.sv
module readout_seq_shadow #(
  parameter int SCLK_DIV    = 4,
  parameter int NUM_KERNELS = 53,
  parameter int START_STEP  = 2,
  parameter int ROT_W       = 5,
  parameter int FOT_W       = 8,
  parameter int START_W     = 5,
  parameter int ROT_RST     = 7,
  parameter int FOT_RST     = 40,
  parameter int CNT_W       = 12,
  parameter int KIDX_W      = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seq_rst_ni,
  input  logic [ROT_W-1:0]   rot_cfg_i,
  input  logic [FOT_W-1:0]   fot_cfg_i,
  input  logic [START_W-1:0] start_cfg_i,
  output logic [CNT_W-1:0]   rot_len_o,
  output logic [CNT_W-1:0]   fot_len_o,
  output logic [KIDX_W-1:0]  start_kernel_o
);
  localparam int MAX_CODE = (NUM_KERNELS - 1) / START_STEP;
  localparam int ROT_OFS  = 2;
  localparam int FOT_MUL  = 4;
  localparam int FOT_OFS  = 2;

  logic [ROT_W-1:0]   rot_q;
  logic [FOT_W-1:0]   fot_q;
  logic [START_W-1:0] start_q;
  int unsigned        code_c;

  // shadows follow the inputs only while the sequencer is held in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q   <= ROT_W'(ROT_RST);
      fot_q   <= FOT_W'(FOT_RST);
      start_q <= '0;
    end else if (!seq_rst_ni) begin
      rot_q   <= rot_cfg_i;
      fot_q   <= fot_cfg_i;
      start_q <= start_cfg_i;
    end
  end

  always_comb begin
    code_c = (int'(start_q) > MAX_CODE) ? MAX_CODE : int'(start_q);
    start_kernel_o = KIDX_W'(code_c * START_STEP);
    rot_len_o = CNT_W'((int'(rot_q) + ROT_OFS) * SCLK_DIV);
    fot_len_o = CNT_W'((FOT_MUL * int'(fot_q) + FOT_OFS) * SCLK_DIV);
  end
endmodule

// File: rtl/readout_seq_trig.sv
module readout_seq_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seq_rst_ni,
  input  logic exposure_i,
  input  logic busy_i,
  input  logic clear_i,
  output logic rise_o,
  output logic pend_o
);
  logic exp_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      exp_q <= exposure_i;
      if (!seq_rst_ni) pend_q <= 1'b0;
      else             pend_q <= ~clear_i & ((busy_i & rise_o) | pend_q);
    end
  end

  assign rise_o = exposure_i & ~exp_q & seq_rst_ni;
  assign pend_o = pend_q;
endmodule

// File: rtl/readout_seq_tmr.sv
module readout_seq_tmr #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import readout_seq_pkg::*;
#(
  parameter int NUM_ROWS     = 1710,
  parameter int NUM_KERNELS  = 53,
  parameter int SCLK_DIV     = 4,
  parameter int KERNEL_SCLKS = 1,
  parameter int START_STEP   = 2,
  parameter int ROT_W        = 5,
  parameter int FOT_W        = 8,
  parameter int START_W      = 5,
  parameter int ROT_RST      = 7,
  parameter int FOT_RST      = 40,
  localparam int ROW_W       = $clog2(NUM_ROWS),
  localparam int KIDX_W      = $clog2(NUM_KERNELS),
  localparam int FOT_MAX     = (4 * (2 ** FOT_W - 1) + 2) * SCLK_DIV,
  localparam int CNT_W       = $clog2(FOT_MAX + 1),
  localparam int KERNEL_CLKS = KERNEL_SCLKS * SCLK_DIV
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               seq_rst_ni,
  input  logic               exposure_i,
  input  logic [ROT_W-1:0]   rot_cfg_i,
  input  logic [FOT_W-1:0]   fot_cfg_i,
  input  logic [START_W-1:0] start_cfg_i,
  output logic               rot_o,
  output logic               fot_o,
  output logic [ROW_W-1:0]   row_o,
  output logic [KIDX_W-1:0]  kernel_o,
  output logic               valid_o
);
  seq_state_e        state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [KIDX_W-1:0] kern_q, kern_d;
  logic [CNT_W-1:0]  rot_len, fot_len, load_val;
  logic [KIDX_W-1:0] start_kernel;
  logic              load, done, rise, pend, clear, busy;
  logic              last_kern, last_row;

  readout_seq_shadow #(
    .SCLK_DIV(SCLK_DIV), .NUM_KERNELS(NUM_KERNELS), .START_STEP(START_STEP),
    .ROT_W(ROT_W), .FOT_W(FOT_W), .START_W(START_W), .ROT_RST(ROT_RST),
    .FOT_RST(FOT_RST), .CNT_W(CNT_W), .KIDX_W(KIDX_W)
  ) u_shadow (
    .clk_i, .rst_ni, .seq_rst_ni, .rot_cfg_i, .fot_cfg_i, .start_cfg_i,
    .rot_len_o(rot_len), .fot_len_o(fot_len), .start_kernel_o(start_kernel)
  );

  readout_seq_trig u_trig (
    .clk_i, .rst_ni, .seq_rst_ni, .exposure_i,
    .busy_i(busy), .clear_i(clear), .rise_o(rise), .pend_o(pend)
  );

  readout_seq_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .len_i(load_val), .done_o(done)
  );

  assign busy      = (state_q != ST_IDLE);
  assign last_kern = (kern_q == KIDX_W'(NUM_KERNELS - 1));
  assign last_row  = (row_q == ROW_W'(NUM_ROWS - 1));

  always_comb begin
    state_d  = state_q;
    row_d    = row_q;
    kern_d   = kern_q;
    load     = 1'b0;
    load_val = fot_len;
    clear    = 1'b0;
    if (!seq_rst_ni) begin
      state_d = ST_IDLE;
      row_d   = '0;
      kern_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (rise) begin
          state_d = ST_FOT;
          load    = 1'b1;
        end
        ST_FOT: if (done) begin
          state_d  = ST_ROT;
          row_d    = '0;
          load     = 1'b1;
          load_val = rot_len;
        end
        ST_ROT: if (done) begin
          state_d  = ST_READ;
          kern_d   = start_kernel;
          load     = 1'b1;
          load_val = CNT_W'(KERNEL_CLKS);
        end
        ST_READ: if (done) begin
          if (!last_kern) begin
            kern_d   = kern_q + 1'b1;
            load     = 1'b1;
            load_val = CNT_W'(KERNEL_CLKS);
          end else if (!last_row) begin
            state_d  = ST_ROT;
            row_d    = row_q + 1'b1;
            load     = 1'b1;
            load_val = rot_len;
          end else begin
            row_d  = '0;
            kern_d = '0;
            if (pend || rise) begin
              // queued exposure: next frame without an idle cycle
              state_d = ST_FOT;
              load    = 1'b1;
              clear   = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      kern_q  <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      kern_q  <= kern_d;
    end
  end

  assign fot_o    = (state_q == ST_FOT);
  assign rot_o    = (state_q == ST_ROT);
  assign valid_o  = (state_q == ST_READ);
  assign row_o    = row_q;
  assign kernel_o = kern_q;
endmodule

// File: rtl/readout_seq_chk.sv
module readout_seq_chk #(
  parameter int ROW_W  = 11,
  parameter int KIDX_W = 6,
  parameter int CNT_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seq_rst_ni,
  input logic              fot_o,
  input logic              rot_o,
  input logic              valid_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [KIDX_W-1:0] kernel_o,
  input logic [CNT_W-1:0]  fot_len_i,
  input logic [CNT_W-1:0]  rot_len_i,
  input logic [KIDX_W-1:0] start_kernel_i
);
  logic [CNT_W:0] fot_run, rot_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fot_run <= '0;
      rot_run <= '0;
    end else begin
      fot_run <= fot_o ? fot_run + 1'b1 : '0;
      rot_run <= rot_o ? rot_run + 1'b1 : '0;
    end
  end

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fot_o, rot_o, valid_o}));

  // R8
  seq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_rst_ni |=> !(fot_o || rot_o || valid_o));

  // R2
  fot_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fot_o) && $past(seq_rst_ni) |-> fot_run == {1'b0, fot_len_i});

  // R3
  rot_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rot_o) && $past(seq_rst_ni) |-> rot_run == {1'b0, rot_len_i});

  // R7
  rot_to_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rot_o) && $past(seq_rst_ni) |-> valid_o);

  // R7
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rot_o) && $past(valid_o) |-> row_o == ROW_W'($past(row_o) + 1'b1));

  // R6
  kern_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && (kernel_o != $past(kernel_o))
      |-> kernel_o == KIDX_W'($past(kernel_o) + 1'b1));

  // R5
  kern_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> kernel_o == start_kernel_i);
endmodule

bind readout_seq readout_seq_chk #(
  .ROW_W(ROW_W), .KIDX_W(KIDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .seq_rst_ni, .fot_o, .rot_o, .valid_o, .row_o, .kernel_o,
  .fot_len_i(fot_len), .rot_len_i(rot_len), .start_kernel_i(start_kernel)
);

// File: tb/readout_seq_test.sv
module readout_seq_test;
  localparam int NR = 3;
  localparam int NK = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_rst_n = 1'b1;
  logic exp_in = 1'b0;
  logic [4:0] rot_cfg = '0;
  logic [7:0] fot_cfg = '0;
  logic [4:0] start_cfg = '0;
  logic rot_o, fot_o, valid_o;
  logic [$clog2(NR)-1:0] row_o;
  logic [$clog2(NK)-1:0] kernel_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  readout_seq #(.NUM_ROWS(NR), .NUM_KERNELS(NK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .seq_rst_ni(seq_rst_n), .exposure_i(exp_in),
    .rot_cfg_i(rot_cfg), .fot_cfg_i(fot_cfg), .start_cfg_i(start_cfg),
    .rot_o(rot_o), .fot_o(fot_o), .row_o(row_o), .kernel_o(kernel_o),
    .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int r, input int f, input int s);
    @(negedge clk);
    seq_rst_n = 1'b0;
    rot_cfg = 5'(r); fot_cfg = 8'(f); start_cfg = 5'(s);
    @(negedge clk);
    @(negedge clk);
    seq_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frames(input int n_fr, input int e_fot, input int e_rot,
                            input int e_first, input bit mid, input string tag);
    int fot_run = 0, rot_run = 0, val_run = 0, frames = 0, rows = 0, exp_row = 0;
    int bad_fot = -1, bad_rot = -1, bad_val = -1, bad_first = -1, bad_last = -1;
    int bad_row = -1, step_bad = 0, excl_bad = 0, samples = 0, mid_st = 0, p_kern = 0;
    bit contig = 1'b1, p_fot = 1'b0, p_rot = 1'b0, p_val = 1'b0;
    @(negedge clk);
    exp_in = 1'b1;
    @(negedge clk);
    chk(fot_o == 1'b1, {tag, " R2 fot_o one cycle after edge"}, int'(fot_o), 1);
    while (samples < 40000) begin
      if (int'(fot_o) + int'(rot_o) + int'(valid_o) > 1) excl_bad++;
      if (fot_o && !p_fot) begin
        exp_row = 0;
        if (frames > 0 && !p_val) contig = 1'b0;
      end
      if (fot_o) fot_run++;
      if (!fot_o && p_fot) begin
        frames++;
        if (fot_run != e_fot && bad_fot < 0) bad_fot = fot_run;
        fot_run = 0;
      end
      if (rot_o && !p_rot) begin
        if (int'(row_o) != exp_row && bad_row < 0) bad_row = int'(row_o);
        exp_row++;
        rows++;
      end
      if (rot_o) rot_run++;
      if (!rot_o && p_rot) begin
        if (rot_run != e_rot && bad_rot < 0) bad_rot = rot_run;
        rot_run = 0;
      end
      if (valid_o && !p_val) begin
        if (int'(kernel_o) != e_first && bad_first < 0) bad_first = int'(kernel_o);
        if (mid && mid_st == 0) begin exp_in = 1'b1; mid_st = 1; end
      end else if (mid_st == 1) begin exp_in = 1'b0; mid_st = 2; end
      else if (mid_st == 2) begin exp_in = 1'b1; mid_st = 3; end
      else if (mid_st == 3) begin exp_in = 1'b0; mid_st = 4; end
      if (valid_o) val_run++;
      if (valid_o && p_val && int'(kernel_o) != p_kern && int'(kernel_o) != p_kern + 1)
        step_bad++;
      if (!valid_o && p_val) begin
        if (val_run != (NK - e_first) * 4 && bad_val < 0) bad_val = val_run;
        if (p_kern != NK - 1 && bad_last < 0) bad_last = p_kern;
        val_run = 0;
      end
      if (!fot_o && !rot_o && !valid_o) break;
      if (samples == 3) exp_in = 1'b0;
      p_fot = fot_o; p_rot = rot_o; p_val = valid_o; p_kern = int'(kernel_o);
      @(negedge clk);
      samples++;
    end
    exp_in = 1'b0;
    chk(bad_fot < 0, {tag, " R2 fot_o length"}, bad_fot, e_fot);
    chk(bad_rot < 0, {tag, " R3 rot_o length"}, bad_rot, e_rot);
    chk(bad_first < 0, {tag, " R5 first kernel"}, bad_first, e_first);
    chk(bad_last < 0, {tag, " R5 last kernel"}, bad_last, NK - 1);
    chk(bad_val < 0, {tag, " R6 valid_o cycles per row"}, bad_val, (NK - e_first) * 4);
    chk(step_bad == 0, {tag, " R6 kernel step"}, step_bad, 0);
    chk(bad_row < 0, {tag, " R7 row index"}, bad_row, 0);
    chk(rows == NR * n_fr, {tag, " R7 row count"}, rows, NR * n_fr);
    chk(frames == n_fr, {tag, " R9 frame count"}, frames, n_fr);
    chk(excl_bad == 0, {tag, " R10 strobe exclusivity"}, excl_bad, 0);
    if (mid) chk(contig, {tag, " R9 back-to-back frame"}, int'(contig), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    seq_rst_n = 1'b1;
    rot_cfg = 5'd3; fot_cfg = 8'd1; start_cfg = 5'd3;
    repeat (4) @(negedge clk);
    chk(!fot_o && !rot_o && !valid_o, "R1 strobes low in reset",
        int'({fot_o, rot_o, valid_o}), 0);
    chk(row_o == '0 && kernel_o == '0, "R1 indices zero in reset",
        int'(row_o) + int'(kernel_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!fot_o && !rot_o && !valid_o, "R1 idle after reset",
        int'({fot_o, rot_o, valid_o}), 0);
  endtask

  task automatic t_hold();
    int hits = 0;
    @(negedge clk);
    seq_rst_n = 1'b0;
    @(negedge clk);
    exp_in = 1'b1;
    repeat (3) @(negedge clk);
    seq_rst_n = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (fot_o || rot_o || valid_o) hits++;
    end
    chk(hits == 0, "R9 held level and edge in reset start nothing", hits, 0);
    exp_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    int hits = 0;
    @(negedge clk);
    exp_in = 1'b1;
    for (int i = 0; i < 2000 && !valid_o; i++) @(negedge clk);
    exp_in = 1'b0;
    chk(valid_o == 1'b1, "R8 readout reached before abort", int'(valid_o), 1);
    seq_rst_n = 1'b0;
    @(negedge clk);
    chk(!fot_o && !rot_o && !valid_o, "R8 sequencer reset stops readout",
        int'({fot_o, rot_o, valid_o}), 0);
    repeat (8) @(negedge clk);
    seq_rst_n = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (fot_o || rot_o || valid_o) hits++;
    end
    chk(hits == 0, "R8 no readout after release without edge", hits, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    // config inputs differ from shadows but sequencer reset never asserted
    run_frames(1, 648, 36, 0, 1'b0, "R4/R8 defaults");
    load_cfg(3, 2, 2);
    run_frames(1, 40, 20, 4, 1'b0, "R5 window");
    load_cfg(0, 0, 31);
    run_frames(1, 8, 8, 8, 1'b0, "R5 clamp");
    load_cfg(31, 1, 4);
    run_frames(1, 24, 132, 8, 1'b0, "R3 max");
    load_cfg(7, 3, 1);
    run_frames(2, 56, 36, 2, 1'b1, "R9 pending");
    t_hold();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule